// File: doc/BRIEF.md
# Frame Sync Pulse Generator with Pixel-Trimmed Edges

This block produces the once-per-frame vertical sync pulse for a TFT-style display timing engine. It keeps its own pixel and line counters and turns them into a linear frame position. The pulse is placed in whole lines, from a start line and a width counted in lines. Two pixel-granular offsets then move its leading and trailing edges, so the pulse can begin and end part-way through a line. The output polarity is programmable.

Settings arrive on parallel configuration inputs and are captured by a one-cycle write strobe into a pending set. The pending set becomes the active set at the last pixel of a frame, so no frame ever mixes old and new timing. While the block is disabled, the pending set is copied into the active set on every clock. A small controller with four states (`ST_IDLE`, `ST_LEAD`, `ST_PULSE`, `ST_TRAIL`) tracks where the current position falls relative to the pulse window. It moves `ST_IDLE` to a counting state when enabled, moves `ST_LEAD` to `ST_PULSE` at the start position, moves `ST_PULSE` to `ST_TRAIL` at the end position, moves `ST_TRAIL` back to `ST_LEAD` when the frame wraps, and returns from any counting state to `ST_IDLE` when the enable drops.

Top module: `vsync_gen`

## Requirements
- R1: After reset, every setting is zero, so the polarity is active low, and `vsync_o` is 1, its inactive level for that polarity.
- R2: An edge sampled with `en` low clears the position to 0 and drives `vsync_o` to the inactive level (`!pol`) of the active settings held before that edge. Counting restarts from position 0 on the first edge with `en` high.
- R3: The frame position P counts clock edges sampled with `en` high, starting at 0. `vsync_o` after the edge that consumes position P shows P. The pulse begins at P = `cfg_start_line` × `cfg_htotal` + `cfg_start_ofs`.
- R4: The last asserted position is E − 1, where E = (`cfg_start_line` + `cfg_width` + 1) × `cfg_htotal` + `cfg_stop_ofs`. The pulse therefore lasts (`cfg_width` + 1) × `cfg_htotal` − `cfg_start_ofs` + `cfg_stop_ofs` clocks.
- R5: With `cfg_pol` = 1 the pulse is driven high and the idle level is low. With `cfg_pol` = 0 the pulse is driven low and the idle level is high.
- R6: The pixel counter wraps after `cfg_htotal` − 1, and the line counter advances on that wrap and itself wraps after `cfg_vtotal` − 1. The frame repeats every `cfg_htotal` × `cfg_vtotal` enabled clocks.
- R7: A strobed write made while enabled takes effect from position 0 of the next frame. A write in the cycle that consumes the last position of a frame already applies to the frame that follows.
- R8: While disabled, a write reaches the active settings on the strobe edge. It shows on the idle level one edge later.
- R9: A pulse whose end lies past the frame length is cut at the frame wrap. When the start position is not below the end position, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable; low holds the counters at zero |
| cfg_wr | input | 1 | One-cycle strobe that captures all cfg_* inputs |
| cfg_htotal | input | 10 | Pixel clocks per line |
| cfg_vtotal | input | 10 | Lines per frame |
| cfg_start_line | input | 10 | Line on which the pulse nominally starts |
| cfg_width | input | 7 | Pulse width in lines, minus one |
| cfg_start_ofs | input | 10 | Delay of the leading edge, in pixel clocks |
| cfg_stop_ofs | input | 10 | Delay of the trailing edge, in pixel clocks |
| cfg_pol | input | 1 | 1: active-high pulse, 0: active-low pulse |
| vsync_o | output | 1 | Registered vertical sync output |

## Verification
Two functions can coincide on one edge: the hand-over of pending settings at the frame wrap, and a new write strobe. The bench waits until the position about to be consumed is the last one of a frame, then pulses `cfg_wr` with a fresh set on exactly that edge. It judges the result by checking that the next frame's pulse edges follow the new values rather than the pending ones. A second overlap is a disable that lands in the middle of the pulse; it must bring the output to the idle level at once and restart the position at zero.

// File: rtl/vsync_pkg.sv
package vsync_pkg;

    parameter int unsigned HT_W  = 10;   // horizontal total field width
    parameter int unsigned VT_W  = 10;   // vertical total / start line width
    parameter int unsigned WID_W = 7;    // pulse width field (lines - 1)
    parameter int unsigned OFS_W = 10;   // edge trim offsets, pixel clocks

    localparam int unsigned POS_W = HT_W + VT_W + 1;

    typedef struct packed {
        logic [HT_W-1:0]  ht;
        logic [VT_W-1:0]  vt;
        logic [VT_W-1:0]  sline;
        logic [WID_W-1:0] wid;
        logic [OFS_W-1:0] sofs;
        logic [OFS_W-1:0] eofs;
        logic             pol;
    } vs_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_PULSE = 2'd2,
        ST_TRAIL = 2'd3
    } vs_state_t;

endpackage

// File: rtl/vsync_cfg_regs.sv
module vsync_cfg_regs
    import vsync_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  vs_cfg_t cfg_in,
    input  logic    load,
    output vs_cfg_t act
);

    vs_cfg_t pend_q;
    vs_cfg_t act_q;

    // pending set captures each strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr) begin
            pend_q <= cfg_in;
        end
    end

    // active set swaps on load; a strobe on the load edge is forwarded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (load) begin
            act_q <= wr ? cfg_in : pend_q;
        end
    end

    assign act = act_q;

endmodule

// File: rtl/vsync_timebase.sv
module vsync_timebase
    import vsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [HT_W-1:0]  htotal,
    input  logic [VT_W-1:0]  vtotal,
    output logic [HT_W-1:0]  pix,
    output logic [VT_W-1:0]  line,
    output logic [POS_W-1:0] pos,
    output logic             frame_end
);

    logic [HT_W-1:0]  pix_q;
    logic [VT_W-1:0]  line_q;
    logic [POS_W-1:0] pos_q;
    logic             line_end;

    assign line_end  = (pix_q == (htotal - HT_W'(1)));
    assign frame_end = line_end && (line_q == (vtotal - VT_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q  <= '0;
            line_q <= '0;
            pos_q  <= '0;
        end else if (!en) begin
            pix_q  <= '0;
            line_q <= '0;
            pos_q  <= '0;
        end else if (frame_end) begin
            pix_q  <= '0;
            line_q <= '0;
            pos_q  <= '0;
        end else if (line_end) begin
            pix_q  <= '0;
            line_q <= line_q + VT_W'(1);
            pos_q  <= pos_q + POS_W'(1);
        end else begin
            pix_q  <= pix_q + HT_W'(1);
            pos_q  <= pos_q + POS_W'(1);
        end
    end

    assign pix  = pix_q;
    assign line = line_q;
    assign pos  = pos_q;

endmodule

// File: rtl/vsync_window.sv
module vsync_window
    import vsync_pkg::*;
(
    input  vs_cfg_t          cfg,
    input  logic [POS_W-1:0] pos,
    output logic             before_start,
    output logic             before_end
);

    logic [POS_W-1:0] ht_w;
    logic [POS_W-1:0] start_pos;
    logic [POS_W-1:0] end_line;
    logic [POS_W-1:0] end_pos;

    always_comb begin
        ht_w      = POS_W'(cfg.ht);
        start_pos = POS_W'(cfg.sline) * ht_w + POS_W'(cfg.sofs);
        end_line  = POS_W'(cfg.sline) + POS_W'(cfg.wid) + POS_W'(1);
        end_pos   = end_line * ht_w + POS_W'(cfg.eofs);
    end

    assign before_start = (pos < start_pos);
    assign before_end   = (pos < end_pos);

endmodule

// File: rtl/vsync_gen.sv
module vsync_gen
    import vsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_wr,
    input  logic [HT_W-1:0]  cfg_htotal,
    input  logic [VT_W-1:0]  cfg_vtotal,
    input  logic [VT_W-1:0]  cfg_start_line,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [OFS_W-1:0] cfg_start_ofs,
    input  logic [OFS_W-1:0] cfg_stop_ofs,
    input  logic             cfg_pol,
    output logic             vsync_o
);

    vs_cfg_t          cfg_in;
    vs_cfg_t          act_cfg;
    logic [HT_W-1:0]  pix;
    logic [VT_W-1:0]  line;
    logic [POS_W-1:0] pos;
    logic             frame_end;
    logic             load;
    logic             before_start;
    logic             before_end;
    vs_state_t        state_q;
    vs_state_t        state_d;
    vs_state_t        where_now;
    logic             out_q;

    always_comb begin
        cfg_in.ht    = cfg_htotal;
        cfg_in.vt    = cfg_vtotal;
        cfg_in.sline = cfg_start_line;
        cfg_in.wid   = cfg_width;
        cfg_in.sofs  = cfg_start_ofs;
        cfg_in.eofs  = cfg_stop_ofs;
        cfg_in.pol   = cfg_pol;
    end

    assign load = !en || frame_end;

    vsync_cfg_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .cfg_in (cfg_in),
        .load   (load),
        .act    (act_cfg)
    );

    vsync_timebase u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .htotal    (act_cfg.ht),
        .vtotal    (act_cfg.vt),
        .pix       (pix),
        .line      (line),
        .pos       (pos),
        .frame_end (frame_end)
    );

    vsync_window u_win (
        .cfg          (act_cfg),
        .pos          (pos),
        .before_start (before_start),
        .before_end   (before_end)
    );

    // region of the position consumed on the coming edge
    always_comb begin
        if (before_start) begin
            where_now = ST_LEAD;
        end else if (before_end) begin
            where_now = ST_PULSE;
        end else begin
            where_now = ST_TRAIL;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = en ? where_now : ST_IDLE;
            ST_LEAD:  state_d = !en ? ST_IDLE : where_now;
            ST_PULSE: state_d = !en ? ST_IDLE : where_now;
            ST_TRAIL: state_d = !en ? ST_IDLE : where_now;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register, levels taken from settings in force before the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else if (state_d == ST_PULSE) begin
            out_q <= act_cfg.pol;
        end else begin
            out_q <= !act_cfg.pol;
        end
    end

    assign vsync_o = out_q;

endmodule

// File: rtl/vsync_gen_chk.sv
module vsync_gen_chk
    import vsync_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             vsync_o,
    input vs_state_t        state,
    input vs_cfg_t          act_cfg,
    input logic [HT_W-1:0]  pix,
    input logic [VT_W-1:0]  line,
    input logic [POS_W-1:0] pos,
    input logic             frame_end
);

    p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE && pos == '0));

    p_off_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (vsync_o == !$past(act_cfg.pol)));

    p_pix_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.ht != '0) |-> (pix < act_cfg.ht));

    p_line_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.vt != '0) |-> (line < act_cfg.vt));

    p_wrap_to_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && frame_end) |=> (pos == '0 && pix == '0 && line == '0));

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !frame_end) |=> $stable(act_cfg));

endmodule

bind vsync_gen vsync_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .vsync_o   (vsync_o),
    .state     (state_q),
    .act_cfg   (act_cfg),
    .pix       (pix),
    .line      (line),
    .pos       (pos),
    .frame_end (frame_end)
);

// File: tb/vsync_gen_tb_top.sv
module vsync_gen_tb_top;
    import vsync_pkg::*;

    typedef struct {
        int ht; int vt; int sl; int w; int so; int po; int pol;
    } mcfg_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, en, cfg_wr;
    logic vsync_o;
    mcfg_t drv, m_pend, m_act;
    int    m_pos;
    logic  exp_q;
    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    done   = 0;

    vsync_gen dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .cfg_wr         (cfg_wr),
        .cfg_htotal     (drv.ht[HT_W-1:0]),
        .cfg_vtotal     (drv.vt[VT_W-1:0]),
        .cfg_start_line (drv.sl[VT_W-1:0]),
        .cfg_width      (drv.w[WID_W-1:0]),
        .cfg_start_ofs  (drv.so[OFS_W-1:0]),
        .cfg_stop_ofs   (drv.po[OFS_W-1:0]),
        .cfg_pol        (drv.pol[0]),
        .vsync_o        (vsync_o)
    );

    function automatic mcfg_t zcfg();
        mcfg_t c;
        c.ht = 0; c.vt = 0; c.sl = 0; c.w = 0; c.so = 0; c.po = 0; c.pol = 0;
        return c;
    endfunction

    function automatic bit in_win(int p, mcfg_t c);
        int s, e;
        s = c.sl * c.ht + c.so;
        e = (c.sl + c.w + 1) * c.ht + c.po;
        return (p >= s) && (p < e);
    endfunction

    // reference model built from the requirements
    always @(posedge clk or negedge rst_n) begin : model
        mcfg_t pn;
        if (!rst_n) begin
            m_pend = zcfg(); m_act = zcfg(); m_pos = 0; exp_q = 1'b1;
        end else begin
            pn = cfg_wr ? drv : m_pend;
            if (!en) begin
                exp_q = (m_act.pol == 0);
                m_act = pn;
                m_pos = 0;
            end else begin
                exp_q = in_win(m_pos, m_act) ? (m_act.pol != 0) : (m_act.pol == 0);
                if (m_pos == m_act.ht * m_act.vt - 1) begin
                    m_pos = 0;
                    m_act = pn;
                end else begin
                    m_pos++;
                end
            end
            m_pend = pn;
        end
    end

    task automatic check_eq(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check_eq(int'(vsync_o), int'(exp_q), tag);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_cfg(mcfg_t c);
        drv = c; cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
    endtask

    function automatic mcfg_t mk(int ht, int vt, int sl, int w, int so, int po, int pol);
        mcfg_t c;
        c.ht = ht; c.vt = vt; c.sl = sl; c.w = w; c.so = so; c.po = po; c.pol = pol;
        return c;
    endfunction

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        #(180000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin : main
        int start_at, len;
        mcfg_t c;
        void'($urandom(32'h1d5e_0a17));
        rst_n = 1'b0; en = 1'b0; cfg_wr = 1'b0; drv = zcfg();
        tag = "R1";
        run(3);
        check_eq(int'(vsync_o), 1, "R1 reset level");
        rst_n = 1'b1;
        run(2);
        check_eq(int'(vsync_o), 1, "R1 idle after reset");

        // R8: write while disabled
        tag = "R8";
        write_cfg(mk(10, 6, 1, 1, 3, 4, 1));
        check_eq(int'(vsync_o), 1, "R8 one edge after strobe");
        step();
        check_eq(int'(vsync_o), 0, "R8 new idle level");

        // R3 / R4: measure start and length in one frame
        tag = "R3,R4";
        en = 1'b1;
        start_at = -1; len = 0;
        for (int j = 1; j <= 60; j++) begin
            step();
            if (vsync_o === 1'b1) begin
                if (start_at < 0) start_at = j - 1;
                len++;
            end
        end
        check_eq(start_at, 13, "R3 start position");
        check_eq(len, 21, "R4 pulse length");
        run(60);

        // R5: active-low via frame-boundary update
        tag = "R5,R7";
        write_cfg(mk(10, 6, 1, 1, 3, 4, 0));
        run(130);

        // R7: write coinciding with last position of frame
        tag = "R7";
        while (m_pos != m_act.ht * m_act.vt - 1) step();
        c = mk(8, 5, 2, 0, 5, 1, 1);
        write_cfg(c);
        start_at = -1; len = 0;
        for (int j = 1; j <= 40; j++) begin
            step();
            if (vsync_o === 1'b1) begin
                if (start_at < 0) start_at = j - 1;
                len++;
            end
        end
        check_eq(start_at, 21, "R7 new start in next frame");
        check_eq(len, 4, "R7 new length in next frame");
        run(80);

        // R9: pulse past frame end is cut; inverted window gives none
        tag = "R9";
        write_cfg(mk(10, 6, 4, 3, 0, 0, 1));
        run(150);
        write_cfg(mk(10, 6, 1, 0, 15, 0, 1));
        run(60);
        len = 0;
        for (int j = 0; j < 60; j++) begin
            step();
            if (vsync_o === 1'b1) len++;
        end
        check_eq(len, 0, "R9 empty window");

        // R2: disable in the middle of the pulse
        tag = "R2";
        write_cfg(mk(10, 6, 1, 2, 0, 0, 1));
        while (vsync_o !== 1'b1) step();
        run(3);
        en = 1'b0;
        step();
        check_eq(int'(vsync_o), 0, "R2 idle level on disable");
        run(3);
        en = 1'b1;
        start_at = -1;
        for (int j = 1; j <= 60; j++) begin
            step();
            if (vsync_o === 1'b1 && start_at < 0) start_at = j - 1;
        end
        check_eq(start_at, 10, "R2 restart from origin");

        // R6: constrained random frames
        tag = "R6";
        for (int it = 0; it < 40; it++) begin
            c.ht  = 2 + int'($urandom % 11);
            c.vt  = 2 + int'($urandom % 7);
            c.sl  = int'($urandom % (c.vt + 1));
            c.w   = int'($urandom % 4);
            c.so  = int'($urandom % 16);
            c.po  = int'($urandom % 16);
            c.pol = int'($urandom % 2);
            write_cfg(c);
            run(20 + int'($urandom % 130));
            if ($urandom % 5 == 0) begin
                tag = "R2";
                en = 1'b0;
                run(1 + int'($urandom % 3));
                en = 1'b1;
                tag = "R6";
            end
        end

        done = 1;
        report();
    end

endmodule